// File: doc/BRIEF.md
# Register File Transfer Unit

This unit sits between the floating-point and integer register files and moves one 64-bit operand across in the same cycle. The path is purely combinational. A 2-bit operation code selects one of four transfers:

- a raw 64-bit copy from float to integer;
- a 32-bit float move to integer, which narrows the double to single format and clears the upper word;
- a raw 64-bit copy from integer to float;
- a 32-bit float move from integer, which widens the low single-format word to a double.

The narrowing and widening follow memory store-single and load-single rules. They do not follow arithmetic rounding, so nothing here raises an exception or touches a status flag.

When the record bit is set, the unit also produces a condition-field update. For results bound for the integer file, the update is a signed comparison against zero, written to field 0. For results bound for the float file, the update copies four float status bits and is written to field 1. The register files themselves and the exception logic are outside the block.

Top module: `rf_xfer_unit`

## Requirements
- R1: With op_i = 2'b00 (float to integer, 64-bit), result_o equals src_i bit for bit.
- R2: With op_i = 2'b10 (integer to float, 64-bit), result_o equals src_i bit for bit.
- R3: With op_i = 2'b01 (float to integer, 32-bit), result_o[63:32] is zero. When the double exponent field src_i[62:52] exceeds 896, or src_i[62:0] is zero, result_o[31:0] is {src_i[63:62], src_i[58:29]}.
- R4: With op_i = 2'b01 and a nonzero source whose exponent field is 896 or less, result_o[31:0] is {src_i[63], 8'h00, frac}. Here frac is the low 23 bits of {1, src_i[51:29]} shifted right by (897 - exponent), truncated without rounding. The field is zero when the shift exceeds 23.
- R5: With op_i = 2'b11 (integer to float, 32-bit), let w = src_i[31:0]. If w[30:23] is 1..254, the result is {w[31], w[30], three copies of ~w[30], w[29:0], 29 zeros}. If w[30:23] is 255, or w[30:0] is zero, the three copies are of w[30] instead.
- R6: With op_i = 2'b11 and a single-format subnormal (exponent 0, nonzero fraction with lz leading zeros in w[22:0]), the result is {w[31], 11'(896 - lz), the fraction shifted left by lz+1 in 23 bits, 29 zeros}.
- R7: With rc_i = 1 and op_i[1] = 0, cond_wr_o = 1 and cond_sel_o = 0. cond_o = {LT, GT, EQ, SO}, where LT, GT and EQ compare result_o as a signed 64-bit integer with zero and SO equals so_i.
- R8: With rc_i = 1 and op_i[1] = 1, cond_wr_o = 1, cond_sel_o = 1, and cond_o equals fp_status_i, ordered {FX, FEX, VX, OX}.
- R9: With rc_i = 0, cond_wr_o, cond_sel_o and cond_o are all zero, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 2 | Transfer code: bit 1 set means the destination is the float file, bit 0 set means 32-bit format |
| rc_i | input | 1 | Record bit requesting a condition-field update |
| src_i | input | 64 | Source register value |
| so_i | input | 1 | Summary-overflow bit carried into field 0 |
| fp_status_i | input | 4 | Float status bits {FX, FEX, VX, OX} carried into field 1 |
| result_o | output | 64 | Value for the destination register |
| cond_wr_o | output | 1 | Condition field update is valid |
| cond_sel_o | output | 1 | Field select: 0 for field 0, 1 for field 1 |
| cond_o | output | 4 | Condition field value |

## Verification
The checks are immediate and assume every input is a known 0/1 value once it settles. They also assume op_i only ever carries one of its four codes, which a 2-bit field always does. The random stimulus draws full 64-bit sources. For the narrowing case it often forces the exponent into the 860 to 900 window, so that the denormalising shifts, including those past 23 bits, are reached. For the widening case it often clears the single exponent, so that subnormal normalisation is reached.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  localparam int DW = 64;
  localparam int SW = 32;
  localparam int CW = 4;
  localparam int DEXP_W = 11;
  localparam int SEXP_W = 8;
  localparam int SFRAC_W = 23;
  // narrowing stays in-format above this biased double exponent
  localparam logic [DEXP_W-1:0] DENORM_TOP = 11'd896;

  typedef enum logic [1:0] {
    XOP_F2I_D = 2'b00,
    XOP_F2I_S = 2'b01,
    XOP_I2F_D = 2'b10,
    XOP_I2F_S = 2'b11
  } xop_e;
endpackage

// File: rtl/rfx_narrow.sv
module rfx_narrow
  import rfx_pkg::*;
(
  input  logic [DW-1:0] dbl_i,
  output logic [SW-1:0] sgl_o
);
  logic [DEXP_W-1:0]  exp_d;
  logic [DEXP_W-1:0]  sh;
  logic [SFRAC_W:0]   mant;
  logic [SFRAC_W:0]   mant_sh;

  assign exp_d = dbl_i[62:52];
  assign mant  = {1'b1, dbl_i[51:29]};
  assign sh    = (DENORM_TOP + 11'd1) - exp_d;

  always_comb begin
    mant_sh = '0;
    if (exp_d > DENORM_TOP || dbl_i[62:0] == '0) begin
      sgl_o = {dbl_i[63:62], dbl_i[58:29]};
    end else begin
      if (sh <= 11'(SFRAC_W)) mant_sh = mant >> sh[4:0];
      sgl_o = {dbl_i[63], {SEXP_W{1'b0}}, mant_sh[SFRAC_W-1:0]};
    end
  end
endmodule

// File: rtl/rfx_widen.sv
module rfx_widen
  import rfx_pkg::*;
(
  input  logic [SW-1:0] sgl_i,
  output logic [DW-1:0] dbl_o
);
  logic [SEXP_W-1:0]  exp_s;
  logic [SFRAC_W-1:0] frac;
  logic [4:0]         lz;
  logic               found;
  logic [SFRAC_W-1:0] frac_n;
  logic [DEXP_W-1:0]  exp_n;

  assign exp_s = sgl_i[30:23];
  assign frac  = sgl_i[22:0];

  always_comb begin
    lz = '0;
    found = 1'b0;
    for (int i = SFRAC_W-1; i >= 0; i--) begin
      if (!found && frac[i]) begin
        lz = 5'(SFRAC_W-1-i);
        found = 1'b1;
      end
    end
  end

  assign frac_n = frac << (lz + 5'd1);
  assign exp_n  = DENORM_TOP - {6'd0, lz};

  always_comb begin
    if (exp_s != '0 && exp_s != '1)
      dbl_o = {sgl_i[31:30], {3{~sgl_i[30]}}, sgl_i[29:0], 29'd0};
    else if (exp_s == '1 || frac == '0)
      dbl_o = {sgl_i[31:30], {3{sgl_i[30]}}, sgl_i[29:0], 29'd0};
    else
      dbl_o = {sgl_i[31], exp_n, frac_n, 29'd0};
  end
endmodule

// File: rtl/rfx_cond.sv
module rfx_cond
  import rfx_pkg::*;
(
  input  logic          rc_i,
  input  logic          to_float_i,
  input  logic [DW-1:0] res_i,
  input  logic          so_i,
  input  logic [CW-1:0] fp_status_i,
  output logic          wr_o,
  output logic          sel_o,
  output logic [CW-1:0] cond_o
);
  logic lt, gt, eq;
  assign lt = res_i[DW-1];
  assign eq = (res_i == '0);
  assign gt = !lt && !eq;

  always_comb begin
    wr_o = rc_i;
    sel_o = 1'b0;
    cond_o = '0;
    if (rc_i) begin
      sel_o  = to_float_i;
      cond_o = to_float_i ? fp_status_i : {lt, gt, eq, so_i};
    end
  end
endmodule

// File: rtl/rf_xfer_unit.sv
module rf_xfer_unit
  import rfx_pkg::*;
(
  input  logic [1:0]    op_i,
  input  logic          rc_i,
  input  logic [DW-1:0] src_i,
  input  logic          so_i,
  input  logic [CW-1:0] fp_status_i,
  output logic [DW-1:0] result_o,
  output logic          cond_wr_o,
  output logic          cond_sel_o,
  output logic [CW-1:0] cond_o
);
  xop_e          op;
  logic [SW-1:0] narrowed;
  logic [DW-1:0] widened;

  assign op = xop_e'(op_i);

  rfx_narrow u_narrow (.dbl_i(src_i), .sgl_o(narrowed));
  rfx_widen  u_widen  (.sgl_i(src_i[SW-1:0]), .dbl_o(widened));

  always_comb begin
    unique case (op)
      XOP_F2I_S: result_o = {{(DW-SW){1'b0}}, narrowed};
      XOP_I2F_S: result_o = widened;
      default:   result_o = src_i;
    endcase
  end

  rfx_cond u_cond (
    .rc_i       (rc_i),
    .to_float_i (op_i[1]),
    .res_i      (result_o),
    .so_i       (so_i),
    .fp_status_i(fp_status_i),
    .wr_o       (cond_wr_o),
    .sel_o      (cond_sel_o),
    .cond_o     (cond_o)
  );
endmodule

// File: rtl/rfx_xfer_chk.sv
module rfx_xfer_chk (
  input logic [1:0]  op_i,
  input logic        rc_i,
  input logic [63:0] src_i,
  input logic        so_i,
  input logic [3:0]  fp_status_i,
  input logic [63:0] result_o,
  input logic        cond_wr_o,
  input logic        cond_sel_o,
  input logic [3:0]  cond_o
);
  always_comb begin
    if (op_i == 2'b00)
      p_raw_f2i_r1: assert (result_o == src_i);
    if (op_i == 2'b10)
      p_raw_i2f_r2: assert (result_o == src_i);
    if (op_i == 2'b01)
      p_upper_zero_r3: assert (result_o[63:32] == 32'd0);
    if (op_i == 2'b11)
      p_low_clear_r5: assert (result_o[28:0] == 29'd0);
    if (rc_i && !op_i[1]) begin
      p_one_relation_r7: assert ($countones(cond_o[3:1]) == 1 && !cond_sel_o && cond_wr_o);
      p_eq_zero_r7: assert (cond_o[1] == (result_o == 64'd0));
      p_so_pass_r7: assert (cond_o[0] == so_i);
    end
    if (rc_i && op_i[1])
      p_fp_field_r8: assert (cond_sel_o && cond_wr_o && cond_o == fp_status_i);
    if (!rc_i)
      p_quiet_r9: assert (!cond_wr_o && !cond_sel_o && cond_o == 4'd0);
  end
endmodule

bind rf_xfer_unit rfx_xfer_chk u_chk (.*);

// File: tb/tb_rf_xfer_unit.sv
`timescale 1ns/1ps
module tb_rf_xfer_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = '0;
  logic        rc_i = 1'b0;
  logic [63:0] src_i = '0;
  logic        so_i = 1'b0;
  logic [3:0]  fp_status_i = '0;
  logic [63:0] result_o;
  logic        cond_wr_o, cond_sel_o;
  logic [3:0]  cond_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rf_xfer_unit dut (.*);

  function automatic logic [31:0] ref_narrow(input logic [63:0] d);
    int e = int'(d[62:52]);
    logic [23:0] m;
    if (e > 896 || d[62:0] == 63'd0) return {d[63:62], d[58:29]};
    m = {1'b1, d[51:29]};
    for (int k = e; k < 897; k++) m = m >> 1;
    return {d[63], 8'd0, m[22:0]};
  endfunction

  function automatic logic [63:0] ref_widen(input logic [31:0] w);
    logic [23:0] f;
    int ex;
    if (w[30:23] != 8'd0 && w[30:23] != 8'hFF)
      return {w[31:30], ~w[30], ~w[30], ~w[30], w[29:0], 29'd0};
    if (w[30:23] == 8'hFF || w[22:0] == 23'd0)
      return {w[31:30], w[30], w[30], w[30], w[29:0], 29'd0};
    f = {1'b0, w[22:0]};
    ex = 897;
    do begin f = f << 1; ex--; end while (!f[23]);
    return {w[31], 11'(ex), f[22:0], 29'd0};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] op, input logic rc, input logic [63:0] src,
                       input logic so, input logic [3:0] fs);
    logic [63:0] er;
    logic [3:0]  ec;
    @(posedge clk);
    op_i = op; rc_i = rc; src_i = src; so_i = so; fp_status_i = fs;
    @(negedge clk);
    case (op)
      2'b00: er = src;
      2'b10: er = src;
      2'b01: er = {32'd0, ref_narrow(src)};
      default: er = ref_widen(src[31:0]);
    endcase
    chk(op == 2'b00 ? "R1" : op == 2'b10 ? "R2" : op == 2'b01 ? "R3/R4" : "R5/R6", result_o, er);
    if (!rc) begin
      chk("R9", {61'd0, cond_wr_o, cond_sel_o, |cond_o}, 64'd0);
    end else if (op[1]) begin
      chk("R8", {58'd0, cond_wr_o, cond_sel_o, cond_o}, {58'd0, 1'b1, 1'b1, fs});
    end else begin
      ec = {$signed(er) < 0, $signed(er) > 0, er == 64'd0, so};
      chk("R7", {58'd0, cond_wr_o, cond_sel_o, cond_o}, {58'd0, 1'b1, 1'b0, ec});
    end
  endtask

  initial begin
    #200_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 reset", result_o, 64'd0);
    chk("R9 reset", {60'd0, cond_o}, 64'd0);
    // directed corners
    apply(2'b00, 1'b1, 64'h8000_0000_0000_0001, 1'b1, 4'h0);        // R1 negative, LT
    apply(2'b00, 1'b1, 64'd0, 1'b0, 4'hF);                           // R7 EQ
    apply(2'b10, 1'b1, 64'hDEAD_BEEF_0123_4567, 1'b0, 4'b1010);       // R2, R8
    apply(2'b01, 1'b1, 64'h3FF0_0000_0000_0000, 1'b0, 4'h0);          // R3 1.0
    chk("R3 1.0", result_o, 64'h0000_0000_3F80_0000);
    apply(2'b01, 1'b0, 64'h7FF8_0000_0000_0000, 1'b1, 4'hF);          // R3 NaN, R9
    apply(2'b01, 1'b0, 64'h8000_0000_0000_0000, 1'b0, 4'h0);          // R3 -0
    apply(2'b01, 1'b1, 64'h3800_0000_0000_0000, 1'b0, 4'h0);          // R4 2^-127
    chk("R4 2^-127", result_o, 64'h0000_0000_0040_0000);
    apply(2'b01, 1'b1, 64'hB69F_FFFF_FFFF_FFFF, 1'b0, 4'h0);          // R4 shift 24
    chk("R4 flush", result_o, 64'h0000_0000_8000_0000);
    apply(2'b11, 1'b1, 64'h0000_0000_3F80_8000, 1'b0, 4'h3);          // R5
    chk("R5 1.0039", result_o, 64'h3FF0_1000_0000_0000);
    apply(2'b11, 1'b0, 64'h0000_0000_7F80_0000, 1'b0, 4'h0);          // R5 inf
    chk("R5 inf", result_o, 64'h7FF0_0000_0000_0000);
    apply(2'b11, 1'b0, 64'h0000_0000_7FC0_0000, 1'b0, 4'h0);          // R5 qNaN
    chk("R5 nan", result_o, 64'h7FF8_0000_0000_0000);
    apply(2'b11, 1'b1, 64'hFFFF_FFFF_0000_0001, 1'b0, 4'h5);          // R6 smallest subnormal
    chk("R6 min sub", result_o, 64'h36A0_0000_0000_0000);
    apply(2'b11, 1'b0, 64'h0000_0000_807F_FFFF, 1'b0, 4'h0);          // R6 largest subnormal
    // random
    for (int n = 0; n < 2000; n++) begin
      logic [63:0] s;
      logic [1:0]  op;
      s  = {$urandom, $urandom};
      op = 2'($urandom);
      if (op == 2'b01 && $urandom_range(0, 1) == 1) s[62:52] = 11'(860 + $urandom_range(0, 40));
      if (op == 2'b11 && $urandom_range(0, 2) == 0) s[30:23] = 8'd0;
      apply(op, 1'($urandom), s, 1'($urandom), 4'($urandom));
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule